// File: doc/BRIEF.md
# Fixed-Point Reciprocal Square Root and Square Root Unit

This unit computes both 1/sqrt(D) and sqrt(D) for an unsigned fixed-point operand D. It uses one shared multiplier over a fixed schedule of Newton-Raphson steps. The caller supplies D together with a starting estimate X0 and pulses start.

Each refinement step forms X(i+1) = ½·Xi·(3 − D·Xi²) in three clocks:

1. Square the current estimate.
2. Scale that square by D, and derive the correction ½·(3 − D·Xi²) by complementing the scaled value, adding the constant three and shifting right by one.
3. Multiply the correction by the estimate that was kept aside.

After the last step, one more multiply by D turns the reciprocal root into the root. Both results are registered together and a one-cycle done pulse marks them.

Numbers are unsigned with INT_W integer bits and FRAC_W fraction bits. The defaults give 2 and 16, so 1.0 is 0x10000. The caller keeps D in a normalised range, roughly [0.5, 2), and chooses X0 so that the fixed step count converges. Range reduction and exponent handling are outside this block.

Top module: `nr_rsqrt_unit`

## Requirements
- R1: While reset is asserted and after it is released, rsqrt_o and sqrt_o read 0 and done_o reads 0 until the first operation completes.
- R2: A start accepted at a clock edge produces done_o at the clock edge 3·ITERS+1 edges later, which is 10 edges with the default ITERS=3.
- R3: done_o is high for exactly one cycle per accepted operation.
- R4: rsqrt_o equals ITERS applications of X ← X·(3 − D·X²)/2, starting from X0. Values are unsigned with FRAC_W fraction bits, so the weight of one LSB is 2^-FRAC_W. The result is within 16 LSB of the real-valued recurrence.
- R5: sqrt_o equals D multiplied by the final estimate, within 16 LSB of the real-valued product.
- R6: With D = 1.0 and X0 = 1.0, both rsqrt_o and sqrt_o are exactly 1.0 (0x10000 at default widths).
- R7: A product that reaches 2^INT_W saturates to all ones. When D·X² is 3.0 or larger, the correction term is zero, so the estimate and both results become zero.
- R8: A start pulse while an operation is in progress is ignored. No extra done is produced, and the results belong to the operation already running.
- R9: rsqrt_o and sqrt_o hold their values in every cycle in which done_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| d_i | input | INT_W+FRAC_W | Operand D, unsigned fixed point |
| x0_i | input | INT_W+FRAC_W | Starting estimate of 1/sqrt(D) |
| rsqrt_o | output | INT_W+FRAC_W | Registered reciprocal square root |
| sqrt_o | output | INT_W+FRAC_W | Registered square root |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
The hardest state to reach from the ports is a correction term that collapses to zero. A plain NR unit only gets there if the scaled square D·X² reaches three or the squarer saturates, and sensible estimates never do that. The stimulus forces it with deliberately oversized starting estimates, one just past the threshold and one that saturates the multiplier. A second hard case is a start pulse landing in the middle of the schedule. The bench fires one four cycles into a running operation and then confirms that only one result arrives. A third is a start issued in the very cycle done is high, which exercises the return to idle without a gap.

// File: rtl/nr_rsqrt_pkg.sv
package nr_rsqrt_pkg;
   // Phase of one refinement step; PH_FIN is the closing multiply by D
   typedef enum logic [1:0] {
      PH_SQ    = 2'd0,
      PH_SCALE = 2'd1,
      PH_UPD   = 2'd2,
      PH_FIN   = 2'd3
   } nr_phase_e;
endpackage

// File: rtl/nr_fx_mul.sv
module nr_fx_mul #(
   parameter int INT_W  = 2,
   parameter int FRAC_W = 16,
   parameter bit ROUND  = 1'b1
) (
   input  logic [INT_W+FRAC_W-1:0] a_i,
   input  logic [INT_W+FRAC_W-1:0] b_i,
   output logic [INT_W+FRAC_W-1:0] p_o
);
   localparam int W  = INT_W + FRAC_W;
   localparam int PW = 2 * W + 1;

   logic [PW-1:0] full;
   logic [PW-1:0] adj;
   logic [PW-1:0] shf;

   assign full = PW'(a_i) * PW'(b_i);

   generate
      if (ROUND) begin : g_round
         assign adj = full + (PW'(1) << (FRAC_W - 1));
      end else begin : g_trunc
         assign adj = full;
      end
   endgenerate

   assign shf = adj >> FRAC_W;
   // saturate when the integer part no longer fits
   assign p_o = (|shf[PW-1:W]) ? {W{1'b1}} : shf[W-1:0];
endmodule

// File: rtl/nr_corr.sv
module nr_corr #(
   parameter int INT_W  = 2,
   parameter int FRAC_W = 16
) (
   input  logic [INT_W+FRAC_W-1:0] y_i,
   output logic [INT_W+FRAC_W-1:0] c_o
);
   localparam int W = INT_W + FRAC_W;
   localparam logic [W-1:0] THREE = W'(3) << FRAC_W;

   logic [W-1:0] neg_y;
   logic [W-1:0] diff;
   logic         over;

   assign neg_y = ~y_i + W'(1);
   assign diff  = THREE + neg_y;
   assign over  = (y_i >= THREE);
   assign c_o   = over ? '0 : (diff >> 1);
endmodule

// File: rtl/nr_seq_ctrl.sv
module nr_seq_ctrl
   import nr_rsqrt_pkg::*;
#(
   parameter int ITERS = 3
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      start_i,
   output logic      busy_o,
   output logic      load_o,
   output nr_phase_e phase_o
);
   localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

   logic            busy_q;
   nr_phase_e       phase_q;
   logic [IW-1:0]   iter_q;

   assign load_o  = start_i & ~busy_q;
   assign busy_o  = busy_q;
   assign phase_o = phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q  <= 1'b0;
         phase_q <= PH_SQ;
         iter_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q  <= 1'b1;
            phase_q <= PH_SQ;
            iter_q  <= '0;
         end
      end else begin
         case (phase_q)
            PH_SQ:    phase_q <= PH_SCALE;
            PH_SCALE: phase_q <= PH_UPD;
            PH_UPD: begin
               if (iter_q == LAST) begin
                  phase_q <= PH_FIN;
               end else begin
                  iter_q  <= iter_q + IW'(1);
                  phase_q <= PH_SQ;
               end
            end
            default:  busy_q <= 1'b0;
         endcase
      end
   end

   // R8
   no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && phase_q != PH_FIN) |=> busy_q)
      else $error("operation aborted before its closing phase");

   // R2
   entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_q) |-> (phase_q == PH_SQ && iter_q == '0))
      else $error("operation did not begin at the first phase");

   // R2
   fin_iter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_q && phase_q == PH_FIN) |-> (iter_q == LAST))
      else $error("closing multiply reached before all iterations");
endmodule

// File: rtl/nr_rsqrt_unit.sv
module nr_rsqrt_unit
   import nr_rsqrt_pkg::*;
#(
   parameter int INT_W  = 2,
   parameter int FRAC_W = 16,
   parameter int ITERS  = 3,
   parameter bit ROUND  = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic [INT_W+FRAC_W-1:0] d_i,
   input  logic [INT_W+FRAC_W-1:0] x0_i,
   output logic [INT_W+FRAC_W-1:0] rsqrt_o,
   output logic [INT_W+FRAC_W-1:0] sqrt_o,
   output logic                    done_o
);
   localparam int W = INT_W + FRAC_W;
   localparam logic [W-1:0] THREE_HALF = W'(3) << (FRAC_W - 1);

   generate
      if (INT_W < 2 || FRAC_W < 4 || ITERS < 1) begin : g_bad_prm
         $error("nr_rsqrt_unit: INT_W>=2, FRAC_W>=4 and ITERS>=1 required");
      end
   endgenerate

   logic          busy;
   logic          load;
   nr_phase_e     phase;
   logic [W-1:0]  d_q, a_q, b_q, c_q;
   logic [W-1:0]  opa, opb, prod, corr;

   nr_seq_ctrl #(.ITERS(ITERS)) u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .busy_o  (busy),
      .load_o  (load),
      .phase_o (phase)
   );

   always_comb begin
      case (phase)
         PH_SQ:    begin opa = a_q; opb = a_q; end
         PH_SCALE: begin opa = a_q; opb = d_q; end
         PH_UPD:   begin opa = c_q; opb = b_q; end
         default:  begin opa = b_q; opb = d_q; end
      endcase
   end

   nr_fx_mul #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ROUND(ROUND)) u_mul (
      .a_i (opa),
      .b_i (opb),
      .p_o (prod)
   );

   nr_corr #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_corr (
      .y_i (prod),
      .c_o (corr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         d_q     <= '0;
         a_q     <= '0;
         b_q     <= '0;
         c_q     <= '0;
         rsqrt_o <= '0;
         sqrt_o  <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (load) begin
            d_q <= d_i;
            a_q <= x0_i;
            b_q <= x0_i;
         end else if (busy) begin
            case (phase)
               PH_SQ:    a_q <= prod;
               PH_SCALE: begin
                  a_q <= prod;
                  c_q <= corr;
               end
               PH_UPD: begin
                  a_q <= prod;
                  b_q <= prod;
               end
               default: begin
                  rsqrt_o <= b_q;
                  sqrt_o  <= prod;
                  done_o  <= 1'b1;
               end
            endcase
         end
      end
   end

   // R3
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o)
      else $error("done held longer than one cycle");

   // R9
   hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(rsqrt_o) && $stable(sqrt_o)))
      else $error("results moved without a done pulse");

   // R7
   corr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_q <= THREE_HALF)
      else $error("correction term above one and a half");
endmodule

// File: tb/sim_nr_rsqrt_unit.sv
module sim_nr_rsqrt_unit;
   localparam int    INT_W  = 2;
   localparam int    FRAC_W = 16;
   localparam int    W      = INT_W + FRAC_W;
   localparam int    ITERS  = 3;
   localparam int    LAT    = 3 * ITERS + 1;
   localparam real   ONE    = 65536.0;
   localparam real   TOL    = 16.0 / 65536.0;
   localparam real   MAXV   = 262143.0 / 65536.0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [W-1:0]  d = '0;
   logic [W-1:0]  x0 = '0;
   logic [W-1:0]  rsqrt, sqrt_v;
   logic          done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int ndone  = 0;
   int nissue = 0;

   typedef struct {
      real rs;
      real sq;
      int  t0;
      bit  exact;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   nr_rsqrt_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W), .ITERS(ITERS)) u0 (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .start_i (start),
      .d_i     (d),
      .x0_i    (x0),
      .rsqrt_o (rsqrt),
      .sqrt_o  (sqrt_v),
      .done_o  (done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic real fx2r(input logic [W-1:0] v);
      return $itor(v) / ONE;
   endfunction

   function automatic logic [W-1:0] r2fx(input real r);
      return W'($rtoi(r * ONE));
   endfunction

   function automatic real sat(input real r);
      return (r > MAXV) ? MAXV : r;
   endfunction

   task automatic chk(input bit ok, input string tag, input real act, input real expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%f expected=%f", tag, act, expv);
      end
   endtask

   // caller sits at a falling edge; start is sampled at the next rising edge
   task automatic issue(input real dr, input real xr, input bit record);
      exp_t e;
      real  dq, x, y, c;
      d     = r2fx(dr);
      x0    = r2fx(xr);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (record) begin
         dq = fx2r(d);
         x  = fx2r(x0);
         for (int i = 0; i < ITERS; i++) begin
            y = sat(dq * sat(x * x));
            c = (y >= 3.0) ? 0.0 : (3.0 - y) / 2.0;
            x = sat(c * x);
         end
         e.rs    = x;
         e.sq    = sat(dq * x);
         e.t0    = cyc;
         e.exact = (d == W'(65536)) && (x0 == W'(65536));
         sb.push_back(e);
         nissue++;
      end
   endtask

   // monitor: pops the scoreboard on each done pulse
   bit prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         // R3
         if (prev_done && done) chk(1'b0, "R3 done longer than one cycle", 1.0, 0.0);
         if (done) begin
            ndone++;
            if (sb.size() == 0) begin
               // R8
               chk(1'b0, "R8 unexpected done", 1.0, 0.0);
            end else begin
               exp_t e;
               real  ar, as;
               e  = sb.pop_front();
               ar = fx2r(rsqrt);
               as = fx2r(sqrt_v);
               // R2
               chk((cyc - e.t0) == LAT, "R2 latency", $itor(cyc - e.t0), $itor(LAT));
               if (e.exact) begin
                  // R6
                  chk(rsqrt == W'(65536), "R6 rsqrt exact", ar, 1.0);
                  chk(sqrt_v == W'(65536), "R6 sqrt exact", as, 1.0);
               end else begin
                  // R4 and R7 (zero results when correction clamps)
                  chk((ar - e.rs) <= TOL && (e.rs - ar) <= TOL, "R4/R7 rsqrt", ar, e.rs);
                  // R5
                  chk((as - e.sq) <= TOL && (e.sq - as) <= TOL, "R5 sqrt", as, e.sq);
               end
            end
         end
         prev_done = done;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 5000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<=5000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] hr, hs;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(rsqrt == '0 && sqrt_v == '0 && done == 1'b0, "R1 reset state", fx2r(rsqrt), 0.0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 after release
      chk(rsqrt == '0 && sqrt_v == '0 && done == 1'b0, "R1 idle after reset", fx2r(sqrt_v), 0.0);

      // R6 exact identity, then R9 hold
      issue(1.0, 1.0, 1'b1);
      repeat (LAT) @(negedge clk);
      hr = rsqrt;
      hs = sqrt_v;
      repeat (6) @(negedge clk);
      // R9
      chk(rsqrt == hr && sqrt_v == hs, "R9 results held", fx2r(rsqrt), fx2r(hr));

      issue(0.5, 1.4, 1'b1);
      repeat (LAT) @(negedge clk);
      // back to back: start while done is high
      issue(1.99, 0.71, 1'b1);
      repeat (LAT) @(negedge clk);
      issue(0.75, 1.15, 1'b1);
      repeat (LAT + 2) @(negedge clk);
      issue(1.5, 0.8, 1'b1);
      repeat (LAT + 2) @(negedge clk);
      issue(0.6, 1.0, 1'b1);
      repeat (LAT + 2) @(negedge clk);

      // R7 correction clamps: D*X0^2 above three
      issue(1.9, 1.3, 1'b1);
      repeat (LAT + 2) @(negedge clk);
      // R7 saturating multiplier
      issue(1.9, 1.9, 1'b1);
      repeat (LAT + 2) @(negedge clk);

      // R8 start four cycles into a running operation
      issue(1.2, 0.9, 1'b1);
      repeat (3) @(negedge clk);
      issue(0.5, 1.4, 1'b0);
      repeat (LAT + 8) @(negedge clk);
      // R8
      chk(ndone == nissue, "R8 done count", $itor(ndone), $itor(nissue));
      chk(sb.size() == 0, "R8 scoreboard drained", $itor(sb.size()), 0.0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule